// File: doc/BRIEF.md
# Parallel LCD Bus Write Engine

This block turns 32-bit words from a host into write cycles on an 8080-style parallel panel bus. The bus has an active-low chip select, a register-select line, an active-low write strobe, an active-low panel reset and 18 data lines. The host pushes words into a small transmit FIFO and watches its full flag. It then sets a beat count, a word-length mode, a byte-valid mask and a command/data choice, and pulses a run request. The engine cuts each FIFO word into bus beats and spaces every beat with programmable setup and strobe times. The run flag falls when the last beat has been sent.

A byte-valid mask (bit j set means byte j, bits 8j+7..8j, is valid) selects the bytes of each word that carry payload. The valid bytes are taken in ascending byte order. There are three word-length modes. In 8-bit mode each valid byte is one beat. In 16-bit mode each pair of valid bytes is one beat. In 18-bit mode each word is one beat and the mask is ignored. Command beats (register-select low) and data beats (register-select high) use separate setup and hold counts. All configuration is captured when a run starts, so the host may prepare the next settings while a run is in progress.

Top module: `lcd_wr_engine`

## Requirements
- R1: After reset `run`, `fifo_full` and `fifo_overflow` are 0, `lcd_cs_n` and `lcd_wr_n` are 1 and `lcd_rst_n` is 0.
- R2: `fifo_full` is 1 exactly when the FIFO holds FIFO_DEPTH words (default 4). A write while it is 1 is dropped, and it sets `fifo_overflow`, which stays 1 until reset.
- R3: Mode 2'b00 (8-bit) sends one beat per set mask bit, taking byte j from bits 8j+7..8j in ascending j. The byte appears on `lcd_data[7:0]` and the upper data bits are 0.
- R4: Mode 2'b01 (16-bit) pairs the valid bytes in ascending order. Each pair is one beat, with the lower-numbered byte on `lcd_data[7:0]` and the higher one on `lcd_data[15:8]`. The upper two bits are 0.
- R5: Mode 2'b10 (18-bit) sends exactly one beat per word, equal to word bits 17..0, whatever the mask.
- R6: `lcd_rs` during a run equals `cfg_data_sel` as sampled at the accepted run request: 1 for data, 0 for command.
- R7: Each beat first holds `lcd_cs_n`=0 and `lcd_wr_n`=1 for S+1 cycles. It then holds `lcd_wr_n`=0 for H+1 cycles with `lcd_data` stable. S and H are the data setup and hold fields when `lcd_rs`=1, and the command setup and hold fields when it is 0.
- R8: A run sends exactly `cfg_count` beats, and `run` falls on the edge that ends the last strobe. A word only partly consumed at that point is discarded, so the next run starts on the following word.
- R9: A run request while `run` is 1, or with `cfg_count`=0, is ignored. Configuration changes during a run do not affect it.
- R10: `lcd_cs_n` is 1 whenever no beat is in progress, including while a run waits for FIFO data.
- R11: `lcd_rst_n` equals the inverse of `panel_reset_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Push `host_wdata` into the FIFO |
| host_wdata | input | 32 | Word to push |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| fifo_overflow | output | 1 | Sticky: a write hit a full FIFO |
| cfg_mode | input | 2 | 00 8-bit, 01 16-bit, 10 18-bit |
| cfg_mask | input | 4 | Byte-valid mask, bit j for byte j |
| cfg_data_sel | input | 1 | 1 data beats, 0 command beats |
| cfg_data_setup | input | TIME_W | Data setup count |
| cfg_data_hold | input | TIME_W | Data strobe-low count |
| cfg_cmd_setup | input | TIME_W | Command setup count |
| cfg_cmd_hold | input | TIME_W | Command strobe-low count |
| cfg_count | input | CNT_W | Beats in the run |
| run_set | input | 1 | Run request pulse |
| run | output | 1 | Run in progress |
| panel_reset_req | input | 1 | Request to hold the panel in reset |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_data | output | 18 | Bus data |

## Verification
The assertions assume that the host keeps the 16-bit mode mask to an even number of set bits and never uses mode 2'b11. They also assume the configuration is settled in the cycle of an accepted run request. The stimulus uses only masks 1111, 1100, 0101, 0011 and 0001 and the three defined modes. It drives every input half a cycle away from the clock edge. It writes into a full FIFO only in the one case meant to test the drop.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
  typedef enum logic [1:0] {
    MODE_8  = 2'b00,
    MODE_16 = 2'b01,
    MODE_18 = 2'b10
  } wmode_e;

  localparam int BUS_W  = 18;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE
  } phase_e;
endpackage

// File: rtl/lcdw_fifo.sv
module lcdw_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             full,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLV = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      occ;
  logic             wr_ok;

  assign wr_ok     = wr_en && (occ != FULLV);
  assign full      = (occ == FULLV);
  assign not_empty = (occ != '0);
  assign head      = mem[rp];

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      occ      <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en && !wr_ok) overflow <= 1'b1;
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/lcdw_unpack.sv
module lcdw_unpack
  import lcdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] head,
  input  logic              head_valid,
  input  logic [1:0]        mode,
  input  logic [LANES-1:0]  mask,
  input  logic              busy,
  input  logic              take,
  input  logic              done,
  output logic              beat_valid,
  output logic [BUS_W-1:0]  beat_data,
  output logic              pop
);
  logic [1:0] idx;
  logic [2:0] pc, nb;
  logic       last_beat;

  function automatic logic [7:0] pick(input logic [WORD_W-1:0] w,
                                      input logic [LANES-1:0] m,
                                      input logic [2:0] r);
    logic [7:0] res;
    logic [2:0] seen;
    res  = '0;
    seen = '0;
    for (int j = 0; j < LANES; j++) begin
      if (m[j]) begin
        if (seen == r) res = w[8*j +: 8];
        seen = seen + 3'd1;
      end
    end
    return res;
  endfunction

  always_comb begin
    pc = '0;
    for (int j = 0; j < LANES; j++) pc = pc + {2'b00, mask[j]};
    case (wmode_e'(mode))
      MODE_16: nb = pc >> 1;
      MODE_18: nb = 3'd1;
      default: nb = pc;
    endcase
  end

  always_comb begin
    case (wmode_e'(mode))
      MODE_16: beat_data = {2'b00, pick(head, mask, {idx, 1'b1}),
                            pick(head, mask, {idx, 1'b0})};
      MODE_18: beat_data = head[BUS_W-1:0];
      default: beat_data = {10'd0, pick(head, mask, {1'b0, idx})};
    endcase
  end

  assign beat_valid = head_valid && (nb != 3'd0);
  assign last_beat  = ({1'b0, idx} == nb - 3'd1);
  assign pop = (take && last_beat) || (done && idx != 2'd0) ||
               (busy && head_valid && nb == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (take) begin
      idx <= last_beat ? 2'd0 : idx + 2'd1;
    end else if (done) begin
      idx <= 2'd0;
    end
  end
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
  import lcdw_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [LANES-1:0]  cfg_mask,
  input  logic              cfg_data_sel,
  input  logic [TIME_W-1:0] cfg_data_setup,
  input  logic [TIME_W-1:0] cfg_data_hold,
  input  logic [TIME_W-1:0] cfg_cmd_setup,
  input  logic [TIME_W-1:0] cfg_cmd_hold,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              beat_valid,
  input  logic [BUS_W-1:0]  beat_data,
  output logic              beat_take,
  output logic              xfer_done,
  output logic              busy,
  output logic [1:0]        mode_l,
  output logic [LANES-1:0]  mask_l,
  output logic              cs_n,
  output logic              rs,
  output logic              wr_n,
  output logic [BUS_W-1:0]  data
);
  phase_e            ph;
  logic [TIME_W-1:0] cnt;
  logic [CNT_W-1:0]  rem;
  logic [TIME_W-1:0] ds_l, dh_l, cs_l, ch_l;
  logic [TIME_W-1:0] su_sel, ho_sel;
  logic              strobe_end, last;

  assign su_sel     = rs ? ds_l : cs_l;
  assign ho_sel     = rs ? dh_l : ch_l;
  assign strobe_end = (ph == PH_STROBE) && (cnt == '0);
  assign last       = (rem == CNT_W'(1));
  assign xfer_done  = strobe_end && last;
  assign beat_take  = beat_valid &&
                      (((ph == PH_IDLE) && busy) || (strobe_end && !last));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      rem    <= '0;
      busy   <= 1'b0;
      mode_l <= 2'b00;
      mask_l <= '1;
      ds_l   <= '0;
      dh_l   <= '0;
      cs_l   <= '0;
      ch_l   <= '0;
      cs_n   <= 1'b1;
      rs     <= 1'b0;
      wr_n   <= 1'b1;
      data   <= '0;
    end else begin
      if (start && !busy && cfg_count != '0) begin
        busy   <= 1'b1;
        rem    <= cfg_count;
        mode_l <= cfg_mode;
        mask_l <= cfg_mask;
        rs     <= cfg_data_sel;
        ds_l   <= cfg_data_setup;
        dh_l   <= cfg_data_hold;
        cs_l   <= cfg_cmd_setup;
        ch_l   <= cfg_cmd_hold;
      end
      case (ph)
        PH_IDLE: begin
          if (busy && beat_valid) begin
            cs_n <= 1'b0;
            wr_n <= 1'b1;
            data <= beat_data;
            cnt  <= su_sel;
            ph   <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            wr_n <= 1'b0;
            cnt  <= ho_sel;
            ph   <= PH_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            wr_n <= 1'b1;
            rem  <= rem - 1'b1;
            if (last) begin
              busy <= 1'b0;
              cs_n <= 1'b1;
              ph   <= PH_IDLE;
            end else if (beat_valid) begin
              data <= beat_data;
              cnt  <= su_sel;
              ph   <= PH_SETUP;
            end else begin
              cs_n <= 1'b1;
              ph   <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_wr_engine.sv
module lcd_wr_engine
  import lcdw_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int TIME_W     = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic              fifo_full,
  output logic              fifo_overflow,
  input  logic [1:0]        cfg_mode,
  input  logic [3:0]        cfg_mask,
  input  logic              cfg_data_sel,
  input  logic [TIME_W-1:0] cfg_data_setup,
  input  logic [TIME_W-1:0] cfg_data_hold,
  input  logic [TIME_W-1:0] cfg_cmd_setup,
  input  logic [TIME_W-1:0] cfg_cmd_hold,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              run_set,
  output logic              run,
  input  logic              panel_reset_req,
  output logic              lcd_cs_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rst_n,
  output logic [17:0]       lcd_data
);
  logic [WORD_W-1:0] head;
  logic              head_valid, pop;
  logic              beat_valid, beat_take, xfer_done;
  logic [BUS_W-1:0]  beat_data;
  logic [1:0]        mode_l;
  logic [LANES-1:0]  mask_l;

  lcdw_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(host_wr), .wr_data(host_wdata),
    .rd_en(pop), .head(head), .not_empty(head_valid),
    .full(fifo_full), .overflow(fifo_overflow)
  );

  lcdw_unpack u_unpack (
    .clk(clk), .rst(rst), .head(head), .head_valid(head_valid),
    .mode(mode_l), .mask(mask_l), .busy(run), .take(beat_take),
    .done(xfer_done), .beat_valid(beat_valid), .beat_data(beat_data),
    .pop(pop)
  );

  lcdw_seq #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(run_set), .cfg_mode(cfg_mode),
    .cfg_mask(cfg_mask), .cfg_data_sel(cfg_data_sel),
    .cfg_data_setup(cfg_data_setup), .cfg_data_hold(cfg_data_hold),
    .cfg_cmd_setup(cfg_cmd_setup), .cfg_cmd_hold(cfg_cmd_hold),
    .cfg_count(cfg_count), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_take(beat_take), .xfer_done(xfer_done), .busy(run),
    .mode_l(mode_l), .mask_l(mask_l), .cs_n(lcd_cs_n), .rs(lcd_rs),
    .wr_n(lcd_wr_n), .data(lcd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) lcd_rst_n <= 1'b0;
    else     lcd_rst_n <= !panel_reset_req;
  end
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker (
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic        fifo_full,
  input logic        fifo_overflow,
  input logic        run,
  input logic        lcd_cs_n,
  input logic        lcd_rs,
  input logic        lcd_wr_n,
  input logic [17:0] lcd_data
);
  // R2: a write into a full FIFO raises the overflow flag
  a_r2_full_write_flags: assert property (@(posedge clk) disable iff (rst)
    host_wr && fifo_full |=> fifo_overflow);

  // R2: the overflow flag never clears outside reset
  a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    fifo_overflow |=> fifo_overflow);

  // R7: the strobe only falls after chip select has been low for a cycle
  a_r7_setup_before_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_wr_n) |-> $past(!lcd_cs_n));

  // R7: data is stable while the strobe is low
  a_r7_data_steady: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n && $past(!lcd_wr_n) |-> $stable(lcd_data));

  // R7: strobe low only inside a selected cycle
  a_r7_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n |-> !lcd_cs_n);

  // R6: register select does not move inside a selected stretch
  a_r6_rs_steady: assert property (@(posedge clk) disable iff (rst)
    !lcd_cs_n && $past(!lcd_cs_n) |-> $stable(lcd_rs));

  // R8: run ends on the edge that closes a strobe
  a_r8_end_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(!lcd_wr_n));

  // R10: no chip select outside a run
  a_r10_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    !run |-> lcd_cs_n);
endmodule

bind lcd_wr_engine lcdw_checker u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .fifo_full(fifo_full),
  .fifo_overflow(fifo_overflow), .run(run), .lcd_cs_n(lcd_cs_n),
  .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data)
);

// File: tb/tb_lcd_wr_engine.sv
`timescale 1ns/1ps
module tb_lcd_wr_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        fifo_full, fifo_overflow, run;
  logic [1:0]  cfg_mode = 2'b00;
  logic [3:0]  cfg_mask = 4'hF;
  logic        cfg_data_sel = 1'b1;
  logic [7:0]  cfg_data_setup = 8'd1, cfg_data_hold = 8'd2;
  logic [7:0]  cfg_cmd_setup = 8'd3, cfg_cmd_hold = 8'd0;
  logic [15:0] cfg_count = '0;
  logic        run_set = 1'b0;
  logic        panel_reset_req = 1'b0;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rst_n;
  logic [17:0] lcd_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [17:0] d;
    logic        rs;
    int          su;
    int          ho;
    string       tag;
  } beat_t;
  beat_t exq[$];

  always #10 clk = ~clk;

  lcd_wr_engine dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .fifo_full(fifo_full), .fifo_overflow(fifo_overflow),
    .cfg_mode(cfg_mode), .cfg_mask(cfg_mask), .cfg_data_sel(cfg_data_sel),
    .cfg_data_setup(cfg_data_setup), .cfg_data_hold(cfg_data_hold),
    .cfg_cmd_setup(cfg_cmd_setup), .cfg_cmd_hold(cfg_cmd_hold),
    .cfg_count(cfg_count), .run_set(run_set), .run(run),
    .panel_reset_req(panel_reset_req), .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs),
    .lcd_wr_n(lcd_wr_n), .lcd_rst_n(lcd_rst_n), .lcd_data(lcd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_beat(input logic [17:0] d, input string tag);
    beat_t b;
    b.d   = d;
    b.rs  = cfg_data_sel;
    b.su  = cfg_data_sel ? int'(cfg_data_setup) : int'(cfg_cmd_setup);
    b.ho  = cfg_data_sel ? int'(cfg_data_hold) : int'(cfg_cmd_hold);
    b.tag = tag;
    exq.push_back(b);
  endtask

  // monitor: measures each beat at the bus and compares against the queue
  logic        prev_wr = 1'b1;
  int          su_cnt = 0, lo_cnt = 0;
  logic [17:0] lo_data = '0;
  logic        lo_rs = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!prev_wr && lcd_wr_n) begin
        if (exq.size() == 0) begin
          check(1'b0, "R8 unexpected beat", {14'd0, lo_data}, 32'hffffffff);
        end else begin
          beat_t e;
          e = exq.pop_front();
          check(lo_data == e.d, {e.tag, " data"}, {14'd0, lo_data}, {14'd0, e.d});
          check(lo_rs == e.rs, {"R6 ", e.tag, " rs"}, {31'd0, lo_rs}, {31'd0, e.rs});
          check(su_cnt == e.su + 1 && lo_cnt == e.ho + 1,
                {"R7 ", e.tag, " timing su/lo"},
                (su_cnt << 16) | lo_cnt, ((e.su + 1) << 16) | (e.ho + 1));
        end
        su_cnt = 0;
        lo_cnt = 0;
      end
      if (!lcd_cs_n && lcd_wr_n) su_cnt++;
      if (!lcd_wr_n) begin
        lo_cnt++;
        lo_data = lcd_data;
        lo_rs   = lcd_rs;
      end
      prev_wr = lcd_wr_n;
    end
  end

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    host_wr    = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic start(input logic [1:0] m, input logic [3:0] k, input logic sel,
                       input logic [15:0] n);
    @(negedge clk);
    cfg_mode     = m;
    cfg_mask     = k;
    cfg_data_sel = sel;
    cfg_count    = n;
    run_set      = 1'b1;
    @(negedge clk);
    run_set = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (run && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(!run, {tag, " run cleared"}, {31'd0, run}, 32'd0);
    repeat (3) @(negedge clk);
    check(exq.size() == 0, {tag, " all beats seen"}, exq.size(), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!run && !fifo_full && !fifo_overflow, "R1 flags", {run, fifo_full, fifo_overflow}, 0);
    check(lcd_cs_n && lcd_wr_n, "R1 bus idle", {lcd_cs_n, lcd_wr_n}, 2'b11);

    // R11 panel reset follows the request
    panel_reset_req = 1'b1;
    @(negedge clk);
    check(!lcd_rst_n, "R11 reset asserted", lcd_rst_n, 0);
    panel_reset_req = 1'b0;
    @(negedge clk);
    check(lcd_rst_n, "R11 reset released", lcd_rst_n, 1);

    // R3 8-bit full mask, data timing
    cfg_data_sel = 1'b1;
    expect_beat(18'h11, "R3 b0");
    expect_beat(18'h22, "R3 b1");
    expect_beat(18'h33, "R3 b2");
    expect_beat(18'h44, "R3 b3");
    push(32'h44332211);
    start(2'b00, 4'b1111, 1'b1, 16'd4);
    wait_idle("R3 full");

    // R3 sparse mask, command beats with command timing (R7)
    cfg_data_sel = 1'b0;
    expect_beat(18'hDD, "R3 sparse b0");
    expect_beat(18'hBB, "R3 sparse b2");
    push(32'hAABBCCDD);
    start(2'b00, 4'b0101, 1'b0, 16'd2);
    wait_idle("R3 sparse");

    // R4 16-bit
    cfg_data_sel = 1'b1;
    expect_beat(18'h05678, "R4 lo");
    expect_beat(18'h01234, "R4 hi");
    push(32'h12345678);
    start(2'b01, 4'b1111, 1'b1, 16'd2);
    wait_idle("R4 full");
    expect_beat(18'h0CAFE, "R4 upper pair");
    push(32'hCAFE0000);
    start(2'b01, 4'b1100, 1'b1, 16'd1);
    wait_idle("R4 upper");

    // R5 18-bit, mask ignored
    expect_beat(18'h3ABCD, "R5 w0");
    expect_beat(18'h3FFFF, "R5 w1");
    push(32'h0003ABCD);
    push(32'hFFFFFFFF);
    start(2'b10, 4'b0001, 1'b1, 16'd2);
    wait_idle("R5");

    // R8 partial word is released at the end of a run
    expect_beat(18'h01, "R8 p0");
    expect_beat(18'h02, "R8 p1");
    expect_beat(18'h03, "R8 p2");
    push(32'h04030201);
    push(32'h08070605);
    start(2'b00, 4'b1111, 1'b1, 16'd3);
    wait_idle("R8 part1");
    expect_beat(18'h05, "R8 next word");
    start(2'b00, 4'b1111, 1'b1, 16'd1);
    wait_idle("R8 part2");

    // R2 full flag and dropped write
    push(32'h000000A1);
    push(32'h000000A2);
    push(32'h000000A3);
    check(!fifo_full, "R2 not full at 3", fifo_full, 0);
    push(32'h000000A4);
    check(fifo_full, "R2 full at 4", fifo_full, 1);
    check(!fifo_overflow, "R2 no overflow yet", fifo_overflow, 0);
    push(32'h000000EE);
    check(fifo_overflow, "R2 overflow set", fifo_overflow, 1);
    expect_beat(18'hA1, "R2 w0");
    expect_beat(18'hA2, "R2 w1");
    expect_beat(18'hA3, "R2 w2");
    expect_beat(18'hA4, "R2 w3");
    start(2'b00, 4'b0001, 1'b1, 16'd4);
    wait_idle("R2 drain");
    check(!fifo_full, "R2 full cleared", fifo_full, 0);
    expect_beat(18'hB5, "R2 dropped word absent");
    push(32'h000000B5);
    start(2'b00, 4'b0001, 1'b1, 16'd1);
    wait_idle("R2 after");
    check(fifo_overflow, "R2 overflow sticky", fifo_overflow, 1);

    // R9 count zero ignored
    start(2'b00, 4'b1111, 1'b1, 16'd0);
    @(negedge clk);
    check(!run, "R9 zero count ignored", run, 0);

    // R10 run waits deselected on empty FIFO
    start(2'b00, 4'b0011, 1'b1, 16'd2);
    repeat (10) @(negedge clk);
    check(run && lcd_cs_n, "R10 waiting deselected", {run, lcd_cs_n}, 2'b11);
    expect_beat(18'hAA, "R10 b0");
    expect_beat(18'hBB, "R10 b1");
    push(32'hDDCCBBAA);
    wait_idle("R10");

    // R9 requests and config changes during a run have no effect
    expect_beat(18'h61, "R9 b0");
    expect_beat(18'h62, "R9 b1");
    push(32'h00006261);
    start(2'b00, 4'b0011, 1'b1, 16'd2);
    cfg_data_sel   = 1'b0;
    cfg_data_setup = 8'd5;
    cfg_cmd_setup  = 8'd7;
    cfg_mask       = 4'b1111;
    cfg_count      = 16'd5;
    run_set        = 1'b1;
    @(negedge clk);
    run_set = 1'b0;
    push(32'h77777777);
    wait_idle("R9 in-run");
    repeat (40) @(negedge clk);
    check(!run && exq.size() == 0, "R9 no extra beats", {run, 1'b0}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule